// File: doc/BRIEF.md
# I2C Block Transfer Controller

This block turns a single block-transfer request into the string of byte-level commands that an I2C byte engine executes. A requester hands over a device address byte, a one-byte offset inside the device, a length and, for writes, a stream of data bytes. The controller issues START/address bytes, offset bytes, data bytes, STOPs and bus-free gaps to the byte engine one at a time. It reacts to each ACK or NACK that comes back, returns read bytes on an output stream, and ends every request with one success-or-failure status pulse.

Reads in normal mode address the device for writing, send the offset, and then insert a bus-free gap. A repeated START with the read bit follows, with no STOP in between. A legacy mode serves simple memories that take the offset inside the address byte itself. Writes are cut into chunks of at most `CHUNK` bytes. Each chunk ends in a STOP, and its internal write cycle is awaited by polling the device with read-addressed STARTs. The number of polling attempts is bounded.

Top module: `i2cblk_xfer`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid`, `rdata_valid` and `done_valid` are 0.
- R2: A request with `req_len` = 0 produces `done_valid` = 1 with `done_fail` = 0 on the clock after it is accepted, and issues no command to the byte engine.
- R3: A normal-mode read issues, in order: START_WR with `{req_dev[7:1],0}`, WR with the offset, GAP, START_WR with `{req_dev[7:1],1}`, then the data reads. Command codes on `cmd_op` are START_WR=0 (START then write byte), WR=1, RD=2 (read, master ACK), RD_LAST=3 (read, master NACK then STOP), STOP=4, GAP=5.
- R4: A legacy-mode read (`req_legacy`=1) issues START_WR with `{req_off[6:0],1}` as its only address byte, followed directly by the data reads.
- R5: A read of N bytes issues N-1 RD commands and then one RD_LAST. The returned bytes appear on the `rdata` stream in order and are held stable while `rdata_ready` is low.
- R6: A NACK on any address or offset byte causes a STOP command and then a failure status; no further bus command follows.
- R7: A write of N bytes is split into chunks of min(remaining, CHUNK=4) bytes. Each chunk is START_WR with `{req_dev[7:1],0}` (legacy: `{offset[6:0],0}`), then WR with the offset (normal mode only), then the chunk's data bytes taken from the `wdata` stream, then STOP. The offset used by the next chunk is larger by the chunk size.
- R8: After each chunk's STOP, the controller sends START_WR with `{req_dev[7:1],1}`. On NACK it sends STOP and retries. On ACK it issues one RD_LAST, discards the result, and then starts the next chunk or reports success.
- R9: After POLL_MAX=100 NACKed polling attempts for one chunk, each followed by its STOP, the controller reports failure. Exactly POLL_MAX-1 NACKs followed by an ACK still succeeds.
- R10: A NACK on any write data byte causes a STOP and then a failure status.
- R11: At most one command is outstanding at the engine: no new `cmd_valid` appears until the previous command's response has arrived. A `wdata` byte is consumed only together with a WR command, and `done_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_legacy | input | 1 | Offset carried in address byte |
| req_dev | input | 8 | Device address in bits 7:1 |
| req_off | input | 8 | Starting offset |
| req_len | input | LEN_W | Byte count |
| wdata_valid | input | 1 | Write byte present |
| wdata_ready | output | 1 | Write byte taken |
| wdata | input | 8 | Write byte |
| rdata_valid | output | 1 | Read byte present |
| rdata_ready | input | 1 | Read byte taken |
| rdata | output | 8 | Read byte |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fail | output | 1 | Completion status, 1 = failure |
| cmd_valid | output | 1 | Command to byte engine |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Byte for START_WR / WR |
| rsp_valid | input | 1 | Engine response pulse |
| rsp_ack | input | 1 | 1 = slave ACKed |
| rsp_data | input | 8 | Byte returned by a read |

## Verification
The bench targets NACKs at each distinct point of a transfer: the first address, the offset, the read-direction address, and a write data byte. A controller that skipped the STOP would leave the bus held, and one that carried on would issue commands the expected transcript does not contain. It runs polling to exactly POLL_MAX-1 NACKs and to POLL_MAX NACKs, where an off-by-one counter turns success into failure or the reverse. It also covers chunk splits with a short final chunk, where a wrong offset advance or chunk count shows as a wrong offset byte. Single-byte reads and zero-length requests are exercised too; a wrong last-byte rule would issue RD instead of RD_LAST, and a missing zero-length rule would hang or touch the bus.

// File: rtl/i2cblk_pkg.sv
package i2cblk_pkg;

    typedef enum logic [2:0] {
        OP_START_WR = 3'd0,
        OP_WR       = 3'd1,
        OP_RD       = 3'd2,
        OP_RD_LAST  = 3'd3,
        OP_STOP     = 3'd4,
        OP_GAP      = 3'd5
    } cmd_op_e;

    typedef enum logic [3:0] {
        S_ADDR_W,
        S_OFF,
        S_GAP,
        S_ADDR_R,
        S_RDATA,
        S_WDATA,
        S_CSTOP,
        S_POLL,
        S_PSTOP,
        S_DISCARD,
        S_ERRSTOP
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ISSUE,
        PH_WAIT,
        PH_PUSH
    } phase_e;

    function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
        return {a, rd};
    endfunction

endpackage

// File: rtl/i2cblk_cmd_enc.sv
module i2cblk_cmd_enc
    import i2cblk_pkg::*;
(
    input  step_e       step,
    input  logic        legacy,
    input  logic [7:0]  dev,
    input  logic [7:0]  off,
    input  logic [7:0]  wbyte,
    input  logic        last,
    output cmd_op_e     op,
    output logic [7:0]  cbyte
);
    always_comb begin
        op    = OP_STOP;
        cbyte = 8'h00;
        case (step)
            S_ADDR_W: begin
                op    = OP_START_WR;
                cbyte = legacy ? addr_byte(off[6:0], 1'b0) : addr_byte(dev[7:1], 1'b0);
            end
            S_OFF: begin
                op    = OP_WR;
                cbyte = off;
            end
            S_GAP:   op = OP_GAP;
            S_ADDR_R: begin
                op    = OP_START_WR;
                cbyte = legacy ? addr_byte(off[6:0], 1'b1) : addr_byte(dev[7:1], 1'b1);
            end
            S_RDATA: op = last ? OP_RD_LAST : OP_RD;
            S_WDATA: begin
                op    = OP_WR;
                cbyte = wbyte;
            end
            S_POLL: begin
                op    = OP_START_WR;
                cbyte = addr_byte(dev[7:1], 1'b1);
            end
            S_DISCARD: op = OP_RD_LAST;
            default:   op = OP_STOP;
        endcase
    end
endmodule

// File: rtl/i2cblk_poll_ctr.sv
module i2cblk_poll_ctr #(
    parameter int POLL_MAX = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int PW = $clog2(POLL_MAX + 1);
    localparam logic [PW-1:0] LIMIT = PW'(POLL_MAX);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign exhausted = (cnt == LIMIT);
endmodule

// File: rtl/i2cblk_xfer.sv
module i2cblk_xfer
    import i2cblk_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int CHUNK    = 4,
    parameter int POLL_MAX = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_legacy,
    input  logic [7:0]       req_dev,
    input  logic [7:0]       req_off,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wdata_valid,
    output logic             wdata_ready,
    input  logic [7:0]       wdata,
    output logic             rdata_valid,
    input  logic             rdata_ready,
    output logic [7:0]       rdata,
    output logic             done_valid,
    output logic             done_fail,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [2:0]       cmd_op,
    output logic [7:0]       cmd_byte,
    input  logic             rsp_valid,
    input  logic             rsp_ack,
    input  logic [7:0]       rsp_data
);
    localparam int CW = $clog2(CHUNK + 1);
    localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK);
    localparam logic [LEN_W-1:0] ONE_L   = LEN_W'(1);

    phase_e           phase;
    step_e            step;
    logic             is_wr, legacy;
    logic [7:0]       dev, off, rbyte;
    logic [LEN_W-1:0] rem;
    logic [CW-1:0]    chunk_left;
    logic [CW-1:0]    req_chunk, rem_chunk;
    logic             poll_clr, poll_inc, poll_exh;
    cmd_op_e          op;
    logic             got_rsp;

    assign req_chunk = (req_len > CHUNK_L) ? CW'(CHUNK) : CW'(req_len);
    assign rem_chunk = (rem > CHUNK_L) ? CW'(CHUNK) : CW'(rem);
    assign got_rsp   = (phase == PH_WAIT) && rsp_valid;

    i2cblk_cmd_enc u_enc (
        .step   (step),
        .legacy (legacy),
        .dev    (dev),
        .off    (off),
        .wbyte  (wdata),
        .last   (rem == ONE_L),
        .op     (op),
        .cbyte  (cmd_byte)
    );

    assign poll_clr = got_rsp && (step == S_CSTOP);
    assign poll_inc = got_rsp && (step == S_POLL) && !rsp_ack;

    i2cblk_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk       (clk),
        .rst       (rst),
        .clr       (poll_clr),
        .inc       (poll_inc),
        .exhausted (poll_exh)
    );

    assign cmd_op      = op;
    assign req_ready   = (phase == PH_IDLE);
    assign cmd_valid   = (phase == PH_ISSUE) && ((step != S_WDATA) || wdata_valid);
    assign wdata_ready = (phase == PH_ISSUE) && (step == S_WDATA) && cmd_ready;
    assign rdata_valid = (phase == PH_PUSH);
    assign rdata       = rbyte;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            step       <= S_ADDR_W;
            is_wr      <= 1'b0;
            legacy     <= 1'b0;
            dev        <= '0;
            off        <= '0;
            rbyte      <= '0;
            rem        <= '0;
            chunk_left <= '0;
            done_valid <= 1'b0;
            done_fail  <= 1'b0;
        end else begin
            done_valid <= 1'b0;
            case (phase)
                PH_IDLE: if (req_valid) begin
                    is_wr      <= req_write;
                    legacy     <= req_legacy;
                    dev        <= req_dev;
                    off        <= req_off;
                    rem        <= req_len;
                    chunk_left <= req_chunk;
                    step       <= (!req_write && req_legacy) ? S_ADDR_R : S_ADDR_W;
                    if (req_len == '0) begin
                        done_valid <= 1'b1;
                        done_fail  <= 1'b0;
                    end else begin
                        phase <= PH_ISSUE;
                    end
                end
                PH_ISSUE: if (cmd_valid && cmd_ready) phase <= PH_WAIT;
                PH_WAIT: if (rsp_valid) begin
                    phase <= PH_ISSUE;
                    case (step)
                        S_ADDR_W:  step <= !rsp_ack ? S_ERRSTOP : (legacy ? S_WDATA : S_OFF);
                        S_OFF:     step <= !rsp_ack ? S_ERRSTOP : (is_wr ? S_WDATA : S_GAP);
                        S_GAP:     step <= S_ADDR_R;
                        S_ADDR_R:  step <= rsp_ack ? S_RDATA : S_ERRSTOP;
                        S_RDATA: begin
                            rbyte <= rsp_data;
                            phase <= PH_PUSH;
                        end
                        S_WDATA: begin
                            if (!rsp_ack) begin
                                step <= S_ERRSTOP;
                            end else begin
                                rem        <= rem - 1'b1;
                                off        <= off + 1'b1;
                                chunk_left <= chunk_left - 1'b1;
                                step       <= (chunk_left == CW'(1)) ? S_CSTOP : S_WDATA;
                            end
                        end
                        S_CSTOP:   step <= S_POLL;
                        S_POLL:    step <= rsp_ack ? S_DISCARD : S_PSTOP;
                        S_PSTOP: begin
                            if (poll_exh) begin
                                phase      <= PH_IDLE;
                                done_valid <= 1'b1;
                                done_fail  <= 1'b1;
                            end else begin
                                step <= S_POLL;
                            end
                        end
                        S_DISCARD: begin
                            if (rem == '0) begin
                                phase      <= PH_IDLE;
                                done_valid <= 1'b1;
                                done_fail  <= 1'b0;
                            end else begin
                                step       <= S_ADDR_W;
                                chunk_left <= rem_chunk;
                            end
                        end
                        default: begin
                            phase      <= PH_IDLE;
                            done_valid <= 1'b1;
                            done_fail  <= 1'b1;
                        end
                    endcase
                end
                PH_PUSH: if (rdata_ready) begin
                    if (rem == ONE_L) begin
                        phase      <= PH_IDLE;
                        done_valid <= 1'b1;
                        done_fail  <= 1'b0;
                    end else begin
                        rem   <= rem - 1'b1;
                        phase <= PH_ISSUE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cblk_xfer_chk.sv
module i2cblk_xfer_chk
    import i2cblk_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LEN_W-1:0] req_len,
    input logic             wdata_ready,
    input logic             rdata_valid,
    input logic             rdata_ready,
    input logic [7:0]       rdata,
    input logic             done_valid,
    input logic             done_fail,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic             rsp_valid
);
    logic       outstanding;
    logic [2:0] last_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            last_op     <= 3'd0;
        end else if (cmd_valid && cmd_ready) begin
            outstanding <= 1'b1;
            last_op     <= cmd_op;
        end else if (rsp_valid) begin
            outstanding <= 1'b0;
        end
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !outstanding); // R11
    AST_WDATA_WITH_WR: assert property (@(posedge clk) disable iff (rst)
        wdata_ready |-> (cmd_valid && cmd_op == 3'(OP_WR))); // R7
    AST_FAIL_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fail) |-> (last_op == 3'(OP_STOP))); // R6
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_len == '0) |=> (done_valid && !done_fail)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!cmd_valid && !rdata_valid)); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rdata_valid && !rdata_ready) |=> (rdata_valid && $stable(rdata))); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid); // R11
endmodule

bind i2cblk_xfer i2cblk_xfer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_len     (req_len),
    .wdata_ready (wdata_ready),
    .rdata_valid (rdata_valid),
    .rdata_ready (rdata_ready),
    .rdata       (rdata),
    .done_valid  (done_valid),
    .done_fail   (done_fail),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .rsp_valid   (rsp_valid)
);

// File: tb/tb_i2cblk_xfer.sv
module tb_i2cblk_xfer;
    localparam int POLL_MAX = 100;
    localparam int CHUNK    = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_write = 1'b0, req_legacy = 1'b0;
    logic [7:0] req_dev = '0, req_off = '0, req_len = '0;
    logic       wdata_valid = 1'b0;
    logic [7:0] wdata = '0;
    logic       rdata_ready = 1'b0;
    logic       cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_ack = 1'b0;
    logic [7:0] rsp_data = '0;
    logic       req_ready, wdata_ready, rdata_valid, done_valid, done_fail, cmd_valid;
    logic [7:0] rdata, cmd_byte;
    logic [2:0] cmd_op;

    always #4 clk = ~clk;

    i2cblk_xfer dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_legacy(req_legacy), .req_dev(req_dev), .req_off(req_off), .req_len(req_len),
        .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
        .rdata_valid(rdata_valid), .rdata_ready(rdata_ready), .rdata(rdata),
        .done_valid(done_valid), .done_fail(done_fail),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data)
    );

    typedef struct {
        logic [2:0] op;
        logic [7:0] b;
        logic       ack;
        logic [7:0] d;
        string      tag;
    } ent_t;

    ent_t       eq[$];
    logic [7:0] rq[$];
    logic [7:0] wq[$];

    int  n_chk = 0, n_bad = 0, cyc = 0;
    bit  aborted, exp_fail;
    int  ack_idx, nack_at;
    bit  got_done, got_fail;
    int  done_cyc;
    bit  finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // expected-transcript builders
    task automatic push(input logic [2:0] op, input logic [7:0] b, input logic ack,
                        input logic [7:0] d, input string tag);
        ent_t e;
        e.op = op; e.b = b; e.ack = ack; e.d = d; e.tag = tag;
        eq.push_back(e);
    endtask

    task automatic ex(input logic [2:0] op, input logic [7:0] b, input string tag);
        if (aborted) return;
        ack_idx++;
        if (ack_idx == nack_at) begin
            push(op, b, 1'b0, 8'h00, tag);
            push(3'd4, 8'h00, 1'b1, 8'h00, tag);
            aborted  = 1;
            exp_fail = 1;
        end else begin
            push(op, b, 1'b1, 8'h00, tag);
        end
    endtask

    task automatic build_read(input bit leg, input logic [7:0] dev, input logic [7:0] off, input int len);
        if (leg) begin
            ex(3'd0, {off[6:0], 1'b1}, "R4");
        end else begin
            ex(3'd0, {dev[7:1], 1'b0}, "R3");
            ex(3'd1, off, "R3");
            if (!aborted) push(3'd5, 8'h00, 1'b1, 8'h00, "R3");
            ex(3'd0, {dev[7:1], 1'b1}, "R3");
        end
        if (aborted) return;
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = 8'(off + i) ^ 8'h5A;
            push((i == len - 1) ? 3'd3 : 3'd2, 8'h00, 1'b1, v, "R5");
            rq.push_back(v);
        end
    endtask

    task automatic build_write(input bit leg, input logic [7:0] dev, input logic [7:0] off,
                               input int len, input int pn);
        int rem, n;
        logic [7:0] o;
        rem = len; o = off;
        for (int i = 0; i < len; i++) wq.push_back(8'hC0 + 8'(i));
        while (rem > 0 && !aborted) begin
            n = (rem > CHUNK) ? CHUNK : rem;
            ex(3'd0, leg ? {o[6:0], 1'b0} : {dev[7:1], 1'b0}, "R7");
            if (!leg) ex(3'd1, o, "R7");
            for (int i = 0; i < n; i++) ex(3'd1, 8'hC0 + 8'(len - rem + i), "R10");
            if (aborted) break;
            push(3'd4, 8'h00, 1'b1, 8'h00, "R7");
            for (int p = 0; p < pn; p++) begin
                push(3'd0, {dev[7:1], 1'b1}, 1'b0, 8'h00, "R8");
                push(3'd4, 8'h00, 1'b1, 8'h00, "R8");
                if (p + 1 == POLL_MAX) begin
                    aborted = 1; exp_fail = 1;
                    break;
                end
            end
            if (aborted) break;
            push(3'd0, {dev[7:1], 1'b1}, 1'b1, 8'h00, "R8");
            push(3'd3, 8'h00, 1'b1, 8'hEE, "R8");
            o = o + 8'(n);
            rem = rem - n;
        end
    endtask

    task automatic refresh_w;
        wdata_valid = (wq.size() > 0);
        wdata       = (wq.size() > 0) ? wq[0] : 8'h00;
    endtask

    // byte-engine model: replays the expected transcript and checks each command
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid === 1'b1 && !rst) begin
                logic [2:0] gop;
                logic [7:0] gb;
                bit took;
                cmd_ready = 1'b1;
                #1;
                took = wdata_ready;
                gop  = cmd_op;
                gb   = cmd_byte;
                @(negedge clk);
                cmd_ready = 1'b0;
                if (took && wq.size() > 0) void'(wq.pop_front());
                refresh_w();
                if (eq.size() == 0) begin
                    chk(0, "R11", "unexpected command op", gop, 7);
                    rsp_ack  = 1'b1;
                    rsp_data = 8'h00;
                end else begin
                    ent_t e;
                    e = eq.pop_front();
                    chk(gop == e.op, e.tag, "command op", gop, e.op);
                    if (e.op <= 3'd1) chk(gb == e.b, e.tag, "command byte", gb, e.b);
                    rsp_ack  = e.ack;
                    rsp_data = e.d;
                end
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    // read-stream consumer with back-pressure
    initial begin
        forever begin
            @(negedge clk);
            rdata_ready = (cyc % 3) != 1;
            #1;
            if (rdata_valid && rdata_ready) begin
                if (rq.size() == 0) chk(0, "R5", "unexpected read byte", rdata, 0);
                else begin
                    logic [7:0] x;
                    x = rq.pop_front();
                    chk(rdata == x, "R5", "read byte", rdata, x);
                end
            end
        end
    end

    // completion monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done_valid === 1'b1) begin
                got_done = 1; got_fail = done_fail; done_cyc = cyc;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R11", "watchdog expired", 0, 1);
        report();
    end

    task automatic run(input bit wr, input bit leg, input logic [7:0] dev, input logic [7:0] off,
                       input int len, input int nk, input int pn, input string tag);
        int acc_cyc;
        eq.delete(); rq.delete(); wq.delete();
        aborted = 0; exp_fail = 0; ack_idx = 0; nack_at = nk;
        if (len > 0) begin
            if (wr) build_write(leg, dev, off, len, pn);
            else    build_read(leg, dev, off, len);
        end
        refresh_w();
        got_done = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, tag, "idle before request", req_ready, 1);
        req_write = wr; req_legacy = leg; req_dev = dev; req_off = off; req_len = 8'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        acc_cyc = cyc;
        while (!got_done) @(negedge clk);
        if (len == 0) chk(done_cyc == acc_cyc, "R2", "zero-length done latency", done_cyc - acc_cyc, 0);
        chk(got_fail == exp_fail, tag, "status", got_fail, exp_fail);
        chk(eq.size() == 0, tag, "commands left unissued", eq.size(), 0);
        chk(rq.size() == 0, tag, "read bytes left", rq.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
        chk(rdata_valid == 1'b0, "R1", "rdata_valid after reset", rdata_valid, 0);
        chk(done_valid == 1'b0, "R1", "done_valid after reset", done_valid, 0);

        run(0, 0, 8'hA0, 8'h10, 5, 0, 0, "R3");        // normal read
        run(0, 1, 8'hA0, 8'h22, 3, 0, 0, "R4");        // legacy read
        run(0, 0, 8'hA2, 8'hFF, 1, 0, 0, "R5");        // single byte, last only
        run(0, 0, 8'hA0, 8'h00, 0, 0, 0, "R2");        // zero-length read
        run(1, 0, 8'hA0, 8'h00, 0, 0, 0, "R2");        // zero-length write
        run(0, 0, 8'hA0, 8'h30, 4, 1, 0, "R6");        // NACK on write-direction address
        run(0, 0, 8'hA0, 8'h30, 4, 2, 0, "R6");        // NACK on offset
        run(0, 0, 8'hA0, 8'h30, 4, 3, 0, "R6");        // NACK on read-direction address
        run(1, 0, 8'hA0, 8'hF0, 6, 0, 2, "R7");        // two chunks, polling NACKs
        run(1, 1, 8'hA0, 8'h08, 4, 0, 0, "R7");        // legacy exact chunk
        run(1, 0, 8'hA4, 8'h40, 9, 0, 1, "R8");        // chunks of 4,4,1
        run(1, 0, 8'hA0, 8'h50, 4, 4, 0, "R10");       // NACK on second data byte
        run(1, 1, 8'hA0, 8'h50, 2, 1, 0, "R6");        // legacy write address NACK
        run(1, 0, 8'hA0, 8'h60, 2, 0, POLL_MAX - 1, "R9"); // just within the poll limit
        run(1, 0, 8'hA0, 8'h60, 2, 0, POLL_MAX, "R9");     // poll limit reached
        report();
    end
endmodule